// File: doc/BRIEF.md
# Multi-level page table walker

This block turns a 32-bit logical address into a physical address by reading a tree of translation descriptors from memory. The tree has one to four levels. Run-time configuration sets how many leading address bits are ignored and how wide the index field of each level is. The walk ends at the first level whose index width is zero, or at the first page descriptor it meets, whichever comes first. The address bits left below the last index field used form the page offset, so the page size is implied by the widths and is not programmed on its own.

A request carries the logical address and a 4-bit function code. The walker chooses one of three root pointers (CPU, supervisor, DMA) and reads descriptors through a 32-bit read port that has a request/response handshake. Each table pointer states whether the next table holds 4-byte or 8-byte entries, and the walker scales the index to match. When the walk ends, the walker holds a done flag together with the physical address, the write-protect, cache-inhibit and modified attributes, and a fault code. These stay valid until the next request is accepted.

Each root pointer input is 34 bits: bits 31:0 are the first-level table address, whose bits 3:0 are taken as zero, and bits 33:32 are the descriptor type of that table.

Top module: `xlate_walk`

## Requirements
- R1: Root pointer selection: when function code bit 3 is 1, the DMA root is used. Otherwise, when function code bit 2 and `cfg_sup_en` are both 1, the supervisor root is used. In every other case the CPU root is used.
- R2: Index fields are taken from the most significant bit downward. The top `cfg_shift` bits are ignored. Level 0 (A) uses `cfg_idx_w[4:0]` bits, level 1 (B) uses `[9:5]`, level 2 (C) uses `[14:10]` and level 3 (D) uses `[19:15]`. Changing only the ignored bits does not change the result.
- R3: The descriptor type sits in bits 1:0, with 0 = invalid, 1 = page, 2 = table of 4-byte entries and 3 = table of 8-byte entries. The fetch address is the table base plus index×4 for type 2, or index×8 for type 3. An 8-byte entry whose first word has a nonzero type is followed by a read of the word at +4.
- R4: A 4-byte table descriptor gives the next table base in bits 31:4. For an 8-byte entry, the next table base comes from bits 31:4 of the second word.
- R5: A page descriptor gives the page base in bits 31:8 (taken from the second word for 8-byte entries), CI in bit 6, M in bit 4 and WP in bit 2. The physical address is the page base with every logical bit below the current level's index field passed through in place of the base bits.
- R6: The reported write-protect is the OR of bit 2 of every descriptor read on the walk, the page descriptor included.
- R7: A descriptor of type 0 at any level ends the walk with fault code 1.
- R8: A table descriptor at the last enabled level (level 3, or the next level's width is zero) ends the walk with fault code 2.
- R9: A root whose type is 0 or 1, or a level A width of zero, ends the walk with fault code 3 and no memory read.
- R10: Any fault reports a physical address of 0 and WP, CI and M all 0. A successful walk reports fault code 0.
- R11: One request is accepted at a time, when `req_valid` and `req_ready` are both high. `req_ready` is low the cycle after acceptance. `done` is low the cycle after acceptance, and once high it holds with a stable result until the next acceptance.
- R12: A memory request stays asserted with a stable, word-aligned address until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_laddr | input | 32 | Logical address |
| req_fc | input | 4 | Function code; bits 3 and 2 steer root selection |
| cfg_sup_en | input | 1 | Enables the supervisor root |
| cfg_shift | input | 5 | Count of ignored leading address bits |
| cfg_idx_w | input | 20 | Four 5-bit index widths, level A in the low bits |
| rp_cpu | input | 34 | CPU root: type in 33:32, table address in 31:0 |
| rp_sup | input | 34 | Supervisor root, same layout |
| rp_dma | input | 34 | DMA root, same layout |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Descriptor word address (byte address, aligned) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Walk finished; result valid |
| res_paddr | output | 32 | Physical address |
| res_wp | output | 1 | Accumulated write-protect |
| res_ci | output | 1 | Cache-inhibit of the page |
| res_mod | output | 1 | Modified bit of the page |
| res_fault | output | 2 | 0 none, 1 invalid descriptor, 2 table at last level, 3 unusable root |

## Verification
The bench uses the default four-level build and two run-time shapes. The first is a two-level tree with 10-bit A and B fields and no ignored bits. It covers early page termination, a table at the final level, both entry sizes under the supervisor root, and all three root choices. The second has four ignored bits and a three-level 8/6/6 split with 256-byte pages. It shows that the ignored bits have no effect and that the field positions move with the widths. A memory model that refuses one request cycle in four puts the request-hold rule under load.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int XW_AW = 32;

  typedef enum logic [1:0] {
    DT_INV  = 2'd0,
    DT_PAGE = 2'd1,
    DT_TBL4 = 2'd2,
    DT_TBL8 = 2'd3
  } dtype_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_INVAL = 2'd1,
    FLT_LAST  = 2'd2,
    FLT_ROOT  = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_REQ, ST_RSP, ST_REQ2, ST_RSP2, ST_DONE
  } st_e;

  typedef struct packed {
    logic   ci;
    logic   md;
    logic   wp;
    dtype_e dt;
  } attr_t;

  // Field of width w whose lowest bit sits at position lsb.
  function automatic logic [XW_AW-1:0] field_of(logic [XW_AW-1:0] a, int lsb, int w);
    logic [XW_AW-1:0] m;
    if (w <= 0) m = '0;
    else if (w >= XW_AW) m = '1;
    else m = (XW_AW'(1) << w) - XW_AW'(1);
    return (a >> lsb) & m;
  endfunction

  // All ones below bit position lsb.
  function automatic logic [XW_AW-1:0] low_mask(int lsb);
    if (lsb >= XW_AW) return '1;
    if (lsb <= 0) return '0;
    return (XW_AW'(1) << lsb) - XW_AW'(1);
  endfunction

  function automatic attr_t to_attr(logic [XW_AW-1:0] w);
    attr_t r;
    r.ci = w[6];
    r.md = w[4];
    r.wp = w[2];
    r.dt = dtype_e'(w[1:0]);
    return r;
  endfunction
endpackage

// File: rtl/xw_root_sel.sv
module xw_root_sel
  import xw_pkg::*;
#(
  parameter int RPW = 34
) (
  input  logic           dma,
  input  logic           sup,
  input  logic [RPW-1:0] rp_cpu,
  input  logic [RPW-1:0] rp_sup,
  input  logic [RPW-1:0] rp_dma,
  output logic [XW_AW-1:0] base,
  output dtype_e         fmt
);
  localparam int TYP_LSB = RPW - 2;

  logic [RPW-1:0] pick;
  logic           unused_low;

  always_comb begin
    if (dma)      pick = rp_dma;
    else if (sup) pick = rp_sup;
    else          pick = rp_cpu;
  end

  assign base       = {pick[XW_AW-1:4], 4'b0000};
  assign fmt        = dtype_e'(pick[TYP_LSB +: 2]);
  assign unused_low = ^pick[3:0];
endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
  import xw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int WB     = 5,
  localparam int LW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [XW_AW-1:0]     laddr,
  input  logic [WB-1:0]        shift,
  input  logic [LEVELS*WB-1:0] widths,
  input  logic [LW-1:0]        lvl,
  input  logic [XW_AW-1:0]     base,
  input  dtype_e               fmt,
  output logic [XW_AW-1:0]     fetch,
  output logic [XW_AW-1:0]     pass,
  output logic                 last,
  output logic                 first_zero
);
  logic [WB-1:0]    w_arr [LEVELS];
  logic [XW_AW-1:0] idx;
  int               lsb;
  int               w_cur;

  for (genvar g = 0; g < LEVELS; g++) begin : g_w
    assign w_arr[g] = widths[g*WB +: WB];
  end

  always_comb begin
    int acc;
    acc   = XW_AW - int'(shift);
    w_cur = 0;
    last  = 1'b1;
    for (int j = 0; j < LEVELS; j++) begin
      if (j <= int'(lvl)) acc = acc - int'(w_arr[j]);
      if (j == int'(lvl)) w_cur = int'(w_arr[j]);
      if (j == int'(lvl) + 1) last = (w_arr[j] == '0);
    end
    lsb = (acc < 0) ? 0 : acc;
  end

  assign idx        = field_of(laddr, lsb, w_cur);
  assign fetch      = base + ((fmt == DT_TBL8) ? (idx << 3) : (idx << 2));
  assign pass       = low_mask(lsb);
  assign first_zero = (w_arr[0] == '0);
endmodule

// File: rtl/xw_desc_dec.sv
module xw_desc_dec
  import xw_pkg::*;
(
  input  attr_t            attr,
  input  logic [XW_AW-1:0] bword,
  output logic [XW_AW-1:0] page_base,
  output logic [XW_AW-1:0] tbl_base,
  output logic             is_table
);
  logic unused_bits;

  assign page_base   = {bword[XW_AW-1:8], 8'h00};
  assign tbl_base    = {bword[XW_AW-1:4], 4'h0};
  assign is_table    = (attr.dt == DT_TBL4) || (attr.dt == DT_TBL8);
  assign unused_bits = ^{bword[3:0], attr.ci, attr.md, attr.wp};
endmodule

// File: rtl/xlate_walk.sv
module xlate_walk
  import xw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int WB     = 5,
  parameter int RPW    = 34,
  localparam int LW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [XW_AW-1:0]     req_laddr,
  input  logic [3:0]           req_fc,
  input  logic                 cfg_sup_en,
  input  logic [WB-1:0]        cfg_shift,
  input  logic [LEVELS*WB-1:0] cfg_idx_w,
  input  logic [RPW-1:0]       rp_cpu,
  input  logic [RPW-1:0]       rp_sup,
  input  logic [RPW-1:0]       rp_dma,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [XW_AW-1:0]     mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [XW_AW-1:0]     mem_rsp_data,
  output logic                 done,
  output logic [XW_AW-1:0]     res_paddr,
  output logic                 res_wp,
  output logic                 res_ci,
  output logic                 res_mod,
  output logic [1:0]           res_fault
);
  st_e              st;
  logic [XW_AW-1:0] la;
  logic             is_dma, is_sup;
  logic [XW_AW-1:0] base_q;
  dtype_e           fmt_q;
  logic [LW-1:0]    lvl_q;
  logic             wp_acc;
  attr_t            w0_attr;

  logic [XW_AW-1:0] root_base;
  dtype_e           root_fmt;
  logic [XW_AW-1:0] fetch, pass, page_base, tbl_base;
  logic             last, first_zero, is_table;
  attr_t            rsp_attr, cur_attr;
  logic             unused_fc;

  // Named events for the checker and for readability.
  logic ev_accept, ev_step, need_2nd, root_bad;

  xw_root_sel #(.RPW(RPW)) u_root (
    .dma(is_dma), .sup(is_sup), .rp_cpu(rp_cpu), .rp_sup(rp_sup), .rp_dma(rp_dma),
    .base(root_base), .fmt(root_fmt)
  );

  xw_addr_gen #(.LEVELS(LEVELS), .WB(WB)) u_addr (
    .laddr(la), .shift(cfg_shift), .widths(cfg_idx_w), .lvl(lvl_q),
    .base(base_q), .fmt(fmt_q), .fetch(fetch), .pass(pass),
    .last(last), .first_zero(first_zero)
  );

  assign rsp_attr = to_attr(mem_rsp_data);
  assign cur_attr = (st == ST_RSP2) ? w0_attr : rsp_attr;

  xw_desc_dec u_dec (
    .attr(cur_attr), .bword(mem_rsp_data),
    .page_base(page_base), .tbl_base(tbl_base), .is_table(is_table)
  );

  assign req_ready     = (st == ST_IDLE) || (st == ST_DONE);
  assign ev_accept     = req_valid && req_ready;
  assign mem_req_valid = (st == ST_REQ) || (st == ST_REQ2);
  assign mem_req_addr  = (st == ST_REQ2) ? (fetch + XW_AW'(4)) : fetch;
  assign need_2nd      = (st == ST_RSP) && (fmt_q == DT_TBL8) && (rsp_attr.dt != DT_INV);
  assign ev_step       = mem_rsp_valid && (((st == ST_RSP) && !need_2nd) || (st == ST_RSP2));
  assign root_bad      = (root_fmt == DT_INV) || (root_fmt == DT_PAGE) || first_zero;
  assign unused_fc     = ^req_fc[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      la        <= '0;
      is_dma    <= 1'b0;
      is_sup    <= 1'b0;
      base_q    <= '0;
      fmt_q     <= DT_INV;
      lvl_q     <= '0;
      wp_acc    <= 1'b0;
      w0_attr   <= '0;
      done      <= 1'b0;
      res_paddr <= '0;
      res_wp    <= 1'b0;
      res_ci    <= 1'b0;
      res_mod   <= 1'b0;
      res_fault <= FLT_NONE;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (ev_accept) begin
            la        <= req_laddr;
            is_dma    <= req_fc[3];
            is_sup    <= req_fc[2] & cfg_sup_en;
            done      <= 1'b0;
            res_paddr <= '0;
            res_wp    <= 1'b0;
            res_ci    <= 1'b0;
            res_mod   <= 1'b0;
            res_fault <= FLT_NONE;
            st        <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (root_bad) begin
            done      <= 1'b1;
            res_fault <= FLT_ROOT;
            st        <= ST_DONE;
          end else begin
            base_q <= root_base;
            fmt_q  <= root_fmt;
            lvl_q  <= '0;
            wp_acc <= 1'b0;
            st     <= ST_REQ;
          end
        end
        ST_REQ:  if (mem_req_ready) st <= ST_RSP;
        ST_REQ2: if (mem_req_ready) st <= ST_RSP2;
        ST_RSP: begin
          if (mem_rsp_valid && need_2nd) begin
            w0_attr <= rsp_attr;
            st      <= ST_REQ2;
          end
        end
        default: ;
      endcase

      if (ev_step) begin
        if (cur_attr.dt == DT_INV) begin
          done      <= 1'b1;
          res_fault <= FLT_INVAL;
          st        <= ST_DONE;
        end else if (cur_attr.dt == DT_PAGE) begin
          done      <= 1'b1;
          res_paddr <= (page_base & ~pass) | (la & pass);
          res_wp    <= wp_acc | cur_attr.wp;
          res_ci    <= cur_attr.ci;
          res_mod   <= cur_attr.md;
          res_fault <= FLT_NONE;
          st        <= ST_DONE;
        end else if (is_table && last) begin
          done      <= 1'b1;
          res_fault <= FLT_LAST;
          st        <= ST_DONE;
        end else begin
          base_q <= tbl_base;
          fmt_q  <= cur_attr.dt;
          lvl_q  <= lvl_q + LW'(1);
          wp_acc <= wp_acc | cur_attr.wp;
          st     <= ST_REQ;
        end
      end
    end
  end
endmodule

// File: rtl/xw_check.sv
module xw_check (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        ev_accept,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic [31:0] res_paddr,
  input logic        res_wp,
  input logic        res_ci,
  input logic        res_mod,
  input logic [1:0]  res_fault
);
  // R12: request held with stable address until taken
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R12: descriptor words are word aligned
  a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

  // R11: result held until the next acceptance
  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(req_valid && req_ready) |=> done && $stable(res_paddr) && $stable(res_fault) && $stable(res_wp));

  // R11: acceptance drops done and ready for the following cycle
  a_r11_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !done && !req_ready);

  // R11: no memory traffic while the walker is able to accept
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  // R10: faults carry a cleared address and attributes
  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault != 2'd0 |-> res_paddr == 32'd0 && !res_wp && !res_ci && !res_mod);
endmodule

bind xlate_walk xw_check u_xw_check (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ev_accept(ev_accept), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .res_paddr(res_paddr), .res_wp(res_wp),
  .res_ci(res_ci), .res_mod(res_mod), .res_fault(res_fault)
);

// File: tb/test_xlate_walk.sv
module test_xlate_walk;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic [3:0]  req_fc = '0;
  logic        cfg_sup_en = 1'b0;
  logic [4:0]  cfg_shift = '0;
  logic [19:0] cfg_idx_w = '0;
  logic [33:0] rp_cpu = '0, rp_sup = '0, rp_dma = '0;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, res_wp, res_ci, res_mod;
  logic [31:0] res_paddr;
  logic [1:0]  res_fault;

  always #(CLK_P/2) clk = ~clk;

  xlate_walk i_xlate_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_fc(req_fc), .cfg_sup_en(cfg_sup_en),
    .cfg_shift(cfg_shift), .cfg_idx_w(cfg_idx_w), .rp_cpu(rp_cpu), .rp_sup(rp_sup),
    .rp_dma(rp_dma), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .res_paddr(res_paddr), .res_wp(res_wp), .res_ci(res_ci),
    .res_mod(res_mod), .res_fault(res_fault)
  );

  // Memory model: word store, refuses one cycle in four, answers one cycle later.
  logic [31:0] mem [logic [31:0]];
  int          cyc = 0;
  int          nreads = 0;
  assign mem_req_ready = (cyc % 4) != 3;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
      nreads        <= nreads + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] pa;
    logic        wp, ci, md;
    logic [1:0]  f;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   nres = 0;
  logic done_q = 1'b0;

  // Monitor: compare each new result against the front of the scoreboard.
  always @(negedge clk) begin
    if (done && !done_q) begin
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected result", {32'h0, res_paddr}, 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(res_paddr == e.pa && res_wp == e.wp && res_ci == e.ci && res_mod == e.md && res_fault == e.f,
            e.tag, {27'h0, res_fault, res_mod, res_ci, res_wp, res_paddr},
            {27'h0, e.f, e.md, e.ci, e.wp, e.pa});
      end
      nres++;
    end
    done_q = done;
  end

  // Driver: push the expected item, issue the request, wait for its result.
  task automatic run(input logic [31:0] la, input logic [3:0] fc, input logic [31:0] pa,
                     input logic wp, input logic ci, input logic md, input logic [1:0] f,
                     input string tag);
    exp_t e;
    int   target;
    e.pa = pa; e.wp = wp; e.ci = ci; e.md = md; e.f = f; e.tag = tag;
    q.push_back(e);
    target = nres + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_laddr = la; req_fc = fc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !done, "R11 busy after accept", {62'h0, req_ready, done}, 64'h0);
    while (nres < target) @(negedge clk);
  endtask

  initial begin
    int rd0;
    // Two-level tree, 10/10 split, 4 KiB pages.
    mem[32'h1004] = 32'h0000_2002;
    mem[32'h200C] = 32'h0055_5051;
    mem[32'h1008] = 32'h0000_3006;
    mem[32'h3000] = 32'h0077_7001;
    mem[32'h1010] = 32'h1240_0001;
    mem[32'h1018] = 32'h0000_4002;
    mem[32'h4000] = 32'h0000_5002;
    mem[32'h6018] = 32'h0000_0002;
    mem[32'h601C] = 32'h0000_7000;
    mem[32'h7008] = 32'h0088_8005;
    mem[32'h6020] = 32'h0000_0045;
    mem[32'h6024] = 32'h0600_0000;
    mem[32'h8004] = 32'h0999_9001;
    // Three-level tree, shift 4, 8/6/6 split, 256-byte pages.
    mem[32'h9048] = 32'h0000_A002;
    mem[32'hA034] = 32'h0000_B006;
    mem[32'hB014] = 32'h0ABC_DE41;

    cfg_idx_w = {5'd0, 5'd0, 5'd10, 5'd10};
    rp_cpu = {2'b10, 32'h0000_1000};
    rp_sup = {2'b11, 32'h0000_6000};
    rp_dma = {2'b10, 32'h0000_8000};

    repeat (3) @(negedge clk);
    chk(!done && req_ready && !mem_req_valid, "R11 reset state",
        {61'h0, done, req_ready, mem_req_valid}, 64'h2);
    rst_n = 1'b1;

    run(32'h0040_3ABC, 4'h1, 32'h0055_5ABC, 0, 1, 1, 2'd0, "R2 R3 R5 two-level page");
    run(32'h0080_0123, 4'h1, 32'h0077_7123, 1, 0, 0, 2'd0, "R6 wp from table level");
    run(32'h0123_4567, 4'h1, 32'h1263_4567, 0, 0, 0, 2'd0, "R5 early page pass-through");
    repeat (4) @(negedge clk);
    chk(done && res_paddr == 32'h1263_4567, "R11 result held", {31'h0, done, res_paddr}, {31'h0, 1'b1, 32'h1263_4567});
    run(32'h0140_0000, 4'h1, 32'h0, 0, 0, 0, 2'd1, "R7 R10 invalid descriptor");
    run(32'h0180_0000, 4'h1, 32'h0, 0, 0, 0, 2'd2, "R8 table at last level");
    cfg_sup_en = 1'b1;
    run(32'h00C0_2345, 4'h5, 32'h0088_8345, 1, 0, 0, 2'd0, "R1 R3 R4 supervisor 8-byte table entry");
    run(32'h0100_0010, 4'h6, 32'h0600_0010, 1, 1, 0, 2'd0, "R3 R5 8-byte page entry");
    run(32'h00C0_2345, 4'h1, 32'h0, 0, 0, 0, 2'd1, "R1 cpu root without fc2");
    cfg_sup_en = 1'b0;
    run(32'h00C0_2345, 4'h5, 32'h0, 0, 0, 0, 2'd1, "R1 cpu root when supervisor disabled");
    run(32'h0040_3ABC, 4'hC, 32'h0980_3ABC, 0, 0, 0, 2'd0, "R1 R5 dma root with masked base");

    cfg_shift = 5'd4;
    cfg_idx_w = {5'd0, 5'd6, 5'd6, 5'd8};
    rp_cpu = {2'b10, 32'h0000_9000};
    run(32'hF123_4567, 4'h2, 32'h0ABC_DE67, 1, 1, 0, 2'd0, "R2 R6 three-level with shift");
    run(32'h0123_4567, 4'h2, 32'h0ABC_DE67, 1, 1, 0, 2'd0, "R2 ignored bits no effect");

    rp_dma = {2'b00, 32'h0000_9000};
    rd0 = nreads;
    run(32'h0123_4567, 4'h8, 32'h0, 0, 0, 0, 2'd3, "R9 R10 invalid root type");
    chk(nreads == rd0, "R9 no read on bad root", 64'(nreads), 64'(rd0));
    cfg_idx_w = {5'd0, 5'd6, 5'd6, 5'd0};
    rd0 = nreads;
    run(32'h0123_4567, 4'h1, 32'h0, 0, 0, 0, 2'd3, "R9 zero first width");
    chk(nreads == rd0, "R9 no read on zero width", 64'(nreads), 64'(rd0));
    chk(q.size() == 0, "R11 scoreboard drained", 64'(q.size()), 64'h0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R11 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule